// File: doc/BRIEF.md
# Reference Tick and Seconds Counters

This block keeps time from a fixed reference clock (25 MHz by default). It holds two counters that a processor can read but never change. The tick counter follows the number of reference cycles elapsed. It moves only in coarse steps of 16 cycles, so its four least significant bits are always zero. It returns to zero after exactly one second's worth of cycles. The seconds counter gives the number of whole seconds since the last reset. It advances on the same clock edge on which the tick counter wraps.

Software reaches the counters through a simple register port that carries 32-bit, word-aligned accesses. A request is offered for one cycle on `req_valid`. The port exerts no back-pressure, so every request is accepted on the cycle it is offered. Exactly one cycle later the response appears as a single-cycle `rsp_valid` pulse, together with the read data and an error flag. No write data lines exist, because no register holds writable state. A write is still decoded. If it hits a counter, the counter keeps running undisturbed, the response carries an error, and `ro_write_err` pulses. Read data is little-endian: bits 7:0 hold the least significant byte. The whole block runs in the reference-clock domain.

Top module: `ref_time_regs`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `rsp_valid`, `rsp_err` and `ro_write_err` are 0 and `rsp_rdata` is 0. A read issued on the first cycle out of reset returns 0 from both counters.
- R2: After n rising edges out of reset, the tick counter holds 16·floor(n/16) modulo REF_HZ. It therefore changes only once every 16 cycles, by +16.
- R3: Bits 3:0 of every tick counter read are 0.
- R4: At the step that would reach REF_HZ, the tick counter goes to 0 instead. With REF_HZ = 160, n = 159 reads 144 and n = 160 reads 0.
- R5: After n edges the seconds counter holds floor(n/REF_HZ). It increments on the same edge on which the tick counter wraps.
- R6: A well-formed read returns its result with `rsp_valid` high on the cycle after `req_valid`, with `rsp_err` = 0. The value is the state before that edge's update. Word address 0x0 is the tick counter and 0x4 is the seconds counter.
- R7: A well-formed word write to 0x0 or 0x4 gives `rsp_err` = 1 and `rsp_rdata` = 0, and pulses `ro_write_err` for exactly one cycle. Both counters go on exactly as if no write had occurred.
- R8: An access whose size code `req_size` is not 2'b10 (the word size), or whose address bits 1:0 are nonzero, gives `rsp_err` = 1 and `rsp_rdata` = 0. Such an access never raises `ro_write_err` and never disturbs the counters.
- R9: A word access to an unmapped word address (0x8 or 0xC) gives `rsp_err` = 1 and `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all state and both counters run on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted on the cycle it is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (4) | Byte address of the request |
| req_size | input | 2 | Access size as log2 of bytes; only 2'b10 is legal |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Response error flag |
| rsp_rdata | output | 32 | Read data; 0 on any error |
| ro_write_err | output | 1 | One-cycle pulse for a write aimed at a read-only counter |

## Verification
Two things can happen on the same edge: a register access, and the wrap of the tick counter with the seconds increment it carries. The bench counts edges since reset, waits until that count is exactly one short of REF_HZ, and issues a read of each counter there. It then issues a read and a write on the wrap edge itself. It judges each response against floor arithmetic on the edge count it recorded when it issued the request. A correct block therefore returns the pre-wrap values, and every later read must show that the write left neither counter moved.

// File: rtl/ref_time_pkg.sv
package ref_time_pkg;
  localparam int WORD_W    = 32;
  localparam int REG_TICKS = 0;
  localparam int REG_SECS  = 1;
  localparam int NUM_REGS  = 2;
  localparam logic [1:0] SIZE_WORD = 2'b10;
endpackage

// File: rtl/ref_prescale.sv
module ref_prescale #(
  parameter int QUANTUM = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic step
);
  localparam int QB = (QUANTUM > 1) ? $clog2(QUANTUM) : 1;

  generate
    if (QUANTUM > 1) begin : g_div
      logic [QB-1:0] phase_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
      end
      assign step = &phase_q;
    end else begin : g_thru
      assign step = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/ref_time_count.sv
module ref_time_count #(
  parameter int REF_HZ  = 25000000,
  parameter int QUANTUM = 16,
  parameter int SEC_W   = 32,
  localparam int QUANTA = REF_HZ / QUANTUM,
  localparam int QW     = $clog2(QUANTA)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [QW-1:0]    quanta_q,
  output logic [SEC_W-1:0] secs_q
);
  localparam logic [QW-1:0] LAST = QW'(QUANTA - 1);

  logic at_end;
  assign at_end = (quanta_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quanta_q <= '0;
      secs_q   <= '0;
    end else if (step) begin
      if (at_end) begin
        quanta_q <= '0;
        secs_q   <= secs_q + 1'b1;
      end else begin
        quanta_q <= quanta_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ref_reg_port.sv
module ref_reg_port import ref_time_pkg::*; #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [WORD_W-1:0] tick_word,
  input  logic [WORD_W-1:0] sec_word,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              ro_write_err
);
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0]     word_idx;
  logic              bad_shape, mapped, err_n, ro_hit;
  logic [WORD_W-1:0] rd_mux;

  assign word_idx  = req_addr[ADDR_W-1:2];
  assign bad_shape = (req_addr[1:0] != 2'b00) || (req_size != SIZE_WORD);
  assign mapped    = (int'(word_idx) < NUM_REGS);
  assign err_n     = bad_shape || !mapped || req_write;
  assign ro_hit    = req_write && !bad_shape && mapped;

  always_comb begin
    rd_mux = '0;
    if (word_idx == IW'(REG_TICKS))     rd_mux = tick_word;
    else if (word_idx == IW'(REG_SECS)) rd_mux = sec_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_err      <= 1'b0;
      rsp_rdata    <= '0;
      ro_write_err <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_err      <= req_valid && err_n;
      rsp_rdata    <= (req_valid && !err_n) ? rd_mux : '0;
      ro_write_err <= req_valid && ro_hit;
    end
  end
endmodule

// File: rtl/ref_time_regs.sv
module ref_time_regs import ref_time_pkg::*; #(
  parameter int REF_HZ  = 25000000,
  parameter int QUANTUM = 16,
  parameter int SEC_W   = 32,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              ro_write_err
);
  localparam int QUANTA = REF_HZ / QUANTUM;
  localparam int QW     = $clog2(QUANTA);
  localparam int QSH    = (QUANTUM > 1) ? $clog2(QUANTUM) : 0;

  logic              tick_step;
  logic [QW-1:0]     quanta_q;
  logic [SEC_W-1:0]  secs_q;
  logic [WORD_W-1:0] tick_word, sec_word;

  ref_prescale #(.QUANTUM(QUANTUM)) pre_i (
    .clk(clk), .rst_n(rst_n), .step(tick_step)
  );

  ref_time_count #(.REF_HZ(REF_HZ), .QUANTUM(QUANTUM), .SEC_W(SEC_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .step(tick_step),
    .quanta_q(quanta_q), .secs_q(secs_q)
  );

  assign tick_word = WORD_W'(quanta_q) << QSH;
  assign sec_word  = WORD_W'(secs_q);

  ref_reg_port #(.ADDR_W(ADDR_W)) port_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size),
    .tick_word(tick_word), .sec_word(sec_word),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .ro_write_err(ro_write_err)
  );
endmodule

module ref_time_regs_chk #(
  parameter int QW     = 4,
  parameter int SEC_W  = 32,
  parameter int ADDR_W = 4,
  parameter logic [QW-1:0] LAST = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              tick_step,
  input logic [QW-1:0]     quanta_q,
  input logic [SEC_W-1:0]  secs_q,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [31:0]       rsp_rdata,
  input logic              ro_write_err
);
  // R6
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R6
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_err && !ro_write_err);
  // R2
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_step |=> $stable(quanta_q));
  // R4
  tick_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_step && quanta_q != LAST) |=> quanta_q == QW'($past(quanta_q) + 1'b1));
  // R4
  tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_step && quanta_q == LAST) |=> quanta_q == '0);
  // R5
  sec_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_step && quanta_q == LAST) |=> secs_q == SEC_W'($past(secs_q) + 1'b1));
  // R5
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_step && quanta_q == LAST) |=> $stable(secs_q));
  // R3
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[ADDR_W-1:2] == '0) |=> rsp_rdata[3:0] == 4'h0);
  // R7
  ro_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ro_write_err |-> rsp_valid && rsp_err && rsp_rdata == '0);
  // R7
  ro_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> !ro_write_err);
endmodule

bind ref_time_regs ref_time_regs_chk #(
  .QW(QW), .SEC_W(SEC_W), .ADDR_W(ADDR_W), .LAST(QW'(QUANTA - 1))
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .tick_step(tick_step), .quanta_q(quanta_q),
  .secs_q(secs_q), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata), .ro_write_err(ro_write_err)
);

// File: tb/ref_time_regs_tb_top.sv
`timescale 1ns/1ps
module ref_time_regs_tb_top;
  localparam int REF = 160;
  localparam int QNT = 16;

  typedef struct packed {
    logic [7:0] gap;
    logic       wr;
    logic [3:0] addr;
    logic [1:0] size;
    logic       e_err;
    logic       e_ro;
    logic [1:0] kind;   // 0 tick, 1 seconds, 2 zero
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'd0,  1'b0, 4'h0, 2'b10, 1'b0, 1'b0, 2'd0},
    '{8'd3,  1'b0, 4'h4, 2'b10, 1'b0, 1'b0, 2'd1},
    '{8'd20, 1'b0, 4'h0, 2'b10, 1'b0, 1'b0, 2'd0},
    '{8'd1,  1'b1, 4'h0, 2'b10, 1'b1, 1'b1, 2'd2},
    '{8'd0,  1'b0, 4'h0, 2'b10, 1'b0, 1'b0, 2'd0},
    '{8'd2,  1'b1, 4'h4, 2'b10, 1'b1, 1'b1, 2'd2},
    '{8'd5,  1'b0, 4'h1, 2'b10, 1'b1, 1'b0, 2'd2},
    '{8'd0,  1'b0, 4'h0, 2'b00, 1'b1, 1'b0, 2'd2},
    '{8'd7,  1'b0, 4'h8, 2'b10, 1'b1, 1'b0, 2'd2},
    '{8'd0,  1'b0, 4'hC, 2'b10, 1'b1, 1'b0, 2'd2},
    '{8'd1,  1'b1, 4'h2, 2'b10, 1'b1, 1'b0, 2'd2},
    '{8'd90, 1'b0, 4'h4, 2'b10, 1'b0, 1'b0, 2'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [1:0] req_size = 2'b10;
  logic rsp_valid, rsp_err, ro_write_err;
  logic [31:0] rsp_rdata;

  int checks = 0, errors = 0, edges = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;

  ref_time_regs #(.REF_HZ(REF), .QUANTUM(QNT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .ro_write_err(ro_write_err)
  );

  function automatic logic [31:0] exp_tick(int k);
    return 32'(((k / QNT) * QNT) % REF);
  endfunction
  function automatic logic [31:0] exp_sec(int k);
    return 32'(k / REF);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // issue one access at a negedge; judge the response one edge later
  task automatic access(bit wr, logic [3:0] a, logic [1:0] sz,
                        bit e_err, bit e_ro, int kind, string req);
    int k;
    logic [31:0] e_data;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
    k = edges;
    e_data = (kind == 0) ? exp_tick(k) : (kind == 1) ? exp_sec(k) : 32'h0;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk(rsp_valid == 1'b1, {req, " R6 rsp_valid"}, 32'(rsp_valid), 32'h1);
    chk(rsp_err == e_err, {req, " rsp_err"}, 32'(rsp_err), 32'(e_err));
    chk(rsp_rdata == e_data, {req, " rdata"}, rsp_rdata, e_data);
    chk(ro_write_err == e_ro, {req, " ro_write_err"}, 32'(ro_write_err), 32'(e_ro));
    @(negedge clk);
    chk(ro_write_err == 1'b0 && rsp_valid == 1'b0, {req, " R7 single-cycle pulse"},
        {30'h0, ro_write_err, rsp_valid}, 32'h0);
  endtask

  task automatic wait_edges(int target);
    while (edges < target) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    chk({rsp_valid, rsp_err, ro_write_err} == 3'b0 && rsp_rdata == '0,
        "R1 reset outputs", {28'h0, rsp_valid, rsp_err, ro_write_err, 1'b0}, 32'h0);
    rst_n = 1'b1;
    // R1 first read out of reset returns zero
    access(1'b0, 4'h0, 2'b10, 1'b0, 1'b0, 0, "R1 tick at reset");
    access(1'b0, 4'h4, 2'b10, 1'b0, 1'b0, 1, "R1 seconds at reset");

    // table: R2 R3 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      repeat (int'(VECS[i].gap)) @(negedge clk);
      access(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].e_err,
             VECS[i].e_ro, int'(VECS[i].kind), $sformatf("R2/R6-R9 vec%0d", i));
    end

    // R4 R5 reads one short of and exactly at the wrap
    wait_edges(2 * REF - 1);
    access(1'b0, 4'h0, 2'b10, 1'b0, 1'b0, 0, "R4 tick before wrap");
    wait_edges(3 * REF - 1);
    access(1'b0, 4'h4, 2'b10, 1'b0, 1'b0, 1, "R5 seconds on wrap edge");
    wait_edges(4 * REF);
    access(1'b0, 4'h0, 2'b10, 1'b0, 1'b0, 0, "R4 tick right after wrap");
    // R7 write coinciding with the wrap edge, then counters still exact
    wait_edges(5 * REF - 1);
    access(1'b1, 4'h4, 2'b10, 1'b1, 1'b1, 2, "R7 write on wrap edge");
    access(1'b0, 4'h4, 2'b10, 1'b0, 1'b0, 1, "R5 seconds after write");
    access(1'b0, 4'h0, 2'b10, 1'b0, 1'b0, 0, "R3 tick after write");
    // R2 sweep of tick reads across a quantum boundary
    for (int j = 0; j < 18; j++)
      access(1'b0, 4'h0, 2'b10, 1'b0, 1'b0, 0, "R2 sweep");
    // R8 byte write to tick: no pulse, counters untouched
    access(1'b1, 4'h0, 2'b00, 1'b1, 1'b0, 2, "R8 byte write");
    access(1'b0, 4'h0, 2'b10, 1'b0, 1'b0, 0, "R8 tick after byte write");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule